// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary and 12/24-Hour Modes

This block holds the time-of-day and calendar fields of a PC-style real-time clock: seconds, minutes, hours, day of week, day of month, month, year and century. Every accepted one-second strobe advances the whole set by one second. Carries ripple through to the century. The fields are kept in the encoding that software sees: packed BCD or plain binary, and hours in either 24-hour form or 12-hour form with a PM flag. The block can also apply the spring and autumn daylight-saving jumps.

Software loads any field through a byte write port. While the hold input is high, strobes are dropped, so a full time can be loaded without an update landing in the middle. Each applied update is reported with a one-cycle done pulse. Alarm matching, interrupt flags, the host bus and the clock divider belong to neighbouring blocks.

Top module: `rtc_calendar`

## Requirements
- R1: Synchronous reset sets the raw field bytes to seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x80 and century 0x19. Reset also clears the done pulse.
- R2: A write stores the raw byte in the field chosen by the select input: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century. The value appears on the next clock edge.
- R3: An accepted strobe advances the time by one second, with carries from seconds to minutes to hours to days. The new values and a done pulse exactly one cycle wide appear on the same edge.
- R4: With the binary-mode input at 0, every field counts in packed BCD, and a low nibble that passes 9 carries into the high nibble. With it at 1, every field counts in plain binary.
- R5: With the 24-hour input at 1, hours run 0 to 23. With it at 0, hours run 1 to 12 and bit 7 of the hours byte is PM. Midnight and noon both read 12, and PM is set for hours 12 to 23 (11 AM becomes 0x8C; 11 PM becomes 0x12 of the next day in BCD).
- R6: The day of month wraps after 30 in April, June, September and November, and after 31 in the other months except February. February wraps after 29 in a leap year and after 28 otherwise. A leap year has a year divisible by 4; year 00 is leap only when the century is divisible by 4.
- R7: When the year wraps from 99 to 00, the century takes the value 20 in the active data mode, and bit 7 of the century keeps its written value.
- R8: With daylight saving enabled, on a Sunday (day of week 1) in April with day of month 1 to 7, the time goes from 01:59:59 straight to 03:00:00. With daylight saving disabled, or on any other day, it goes to 02:00:00.
- R9: With daylight saving enabled, on a Sunday in October with day of month 25 to 31, the first time 01:59:59 is reached the time goes back to 01:00:00. A second pass that day goes to 02:00:00. The once-only mark clears at midnight and on reset.
- R10: While hold is high, strobes are dropped. No field changes and no done pulse is produced.
- R11: A strobe that arrives in a write cycle is held until the next cycle without a write. The write lands first, and the update is then applied to the written value.
- R12: Day of week counts 1 to 7 and wraps from 7 to 1. Month counts 1 to 12 and wraps from 12 to 1, carrying into the year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second update strobe |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en_i | input | 1 | Enables daylight-saving jumps |
| hold_i | input | 1 | Drops update strobes while high |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for writes |
| wr_data_i | input | 8 | Raw byte to write |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| cent_o | output | 8 | Century |
| upd_done_o | output | 1 | One-cycle pulse for each applied update |

## Verification
A field write and an update strobe can fall in the same cycle. The bench provokes this by raising both on one edge, with the write aimed at the seconds field. It then expects the written byte and no done pulse on that edge, and on the following edge the written value plus one second together with the done pulse. A second overlap is the autumn rollback meeting its once-only mark. Two passes through 01:59:59 on the same Sunday must give 01:00:00 first and 02:00:00 second.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int FW     = 8;
  localparam int NFIELD = 8;
  localparam int SELW   = $clog2(NFIELD);

  typedef logic [FW-1:0] fld_t;

  typedef enum logic [SELW-1:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
    F_MDAY = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6, F_CENT = 3'd7
  } fsel_e;

  // Stored byte to binary value in the active data mode.
  function automatic fld_t to_bin(fld_t v, logic bin);
    return bin ? v : (fld_t'(v[7:4]) * fld_t'(10)) + fld_t'(v[3:0]);
  endfunction

  // Binary value to stored byte in the active data mode.
  function automatic fld_t from_bin(fld_t v, logic bin);
    return bin ? v : {4'(v / fld_t'(10)), 4'(v % fld_t'(10))};
  endfunction

  function automatic fld_t rst_val(int idx);
    case (idx)
      3, 4, 5: return fld_t'(8'h01);
      6:       return fld_t'(8'h80);
      7:       return fld_t'(8'h19);
      default: return '0;
    endcase
  endfunction

  function automatic fld_t month_len(fld_t mo, logic leap);
    case (mo)
      8'd2:                     return leap ? fld_t'(29) : fld_t'(28);
      8'd4, 8'd6, 8'd9, 8'd11:  return fld_t'(30);
      default:                  return fld_t'(31);
    endcase
  endfunction
endpackage

// File: rtl/rtc_hour_dec.sv
`timescale 1ns/1ps
module rtc_hour_dec
  import rtc_cal_pkg::*;
(
  input  fld_t raw_i,
  input  logic bin_i,
  input  logic h24_i,
  output fld_t hour_o
);
  fld_t h12;
  always_comb begin
    h12 = to_bin({1'b0, raw_i[FW-2:0]}, bin_i);
    if (h24_i)
      hour_o = to_bin(raw_i, bin_i);
    else
      hour_o = ((h12 == fld_t'(12)) ? fld_t'(0) : h12) +
               (raw_i[FW-1] ? fld_t'(12) : fld_t'(0));
  end
endmodule

// File: rtl/rtc_hour_enc.sv
`timescale 1ns/1ps
module rtc_hour_enc
  import rtc_cal_pkg::*;
(
  input  fld_t hour_i,
  input  logic bin_i,
  input  logic h24_i,
  output fld_t raw_o
);
  fld_t h12, enc12;
  logic pm;
  always_comb begin
    pm    = (hour_i >= fld_t'(12));
    h12   = pm ? hour_i - fld_t'(12) : hour_i;
    if (h12 == fld_t'(0)) h12 = fld_t'(12);
    enc12 = from_bin(h12, bin_i);
    raw_o = h24_i ? from_bin(hour_i, bin_i) : {pm, enc12[FW-2:0]};
  end
endmodule

// File: rtl/rtc_cal_next.sv
`timescale 1ns/1ps
module rtc_cal_next
  import rtc_cal_pkg::*;
(
  input  logic [NFIELD-1:0][FW-1:0] cur_i,
  input  logic                      bin_i,
  input  logic                      h24_i,
  input  logic                      dst_i,
  input  logic                      fall_done_i,
  output logic [NFIELD-1:0][FW-1:0] nxt_o,
  output logic                      fall_done_o
);
  fld_t s, m, h, wd, d, mo, y, c, h_n, h_raw, cent20;
  logic c_min, c_hr, c_day, c_mon, c_yr, leap, at_159, sunday;
  logic spring, fall, hour_chg;
  logic [NFIELD-1:0][FW-1:0] nxt_t;

  rtc_hour_dec u_hdec (.raw_i(cur_i[F_HOUR]), .bin_i(bin_i), .h24_i(h24_i), .hour_o(h));
  rtc_hour_enc u_henc (.hour_i(h_n), .bin_i(bin_i), .h24_i(h24_i), .raw_o(h_raw));

  always_comb begin
    s  = to_bin(cur_i[F_SEC],  bin_i);
    m  = to_bin(cur_i[F_MIN],  bin_i);
    wd = to_bin(cur_i[F_WDAY], bin_i);
    d  = to_bin(cur_i[F_MDAY], bin_i);
    mo = to_bin(cur_i[F_MON],  bin_i);
    y  = to_bin(cur_i[F_YEAR], bin_i);
    c  = to_bin({1'b0, cur_i[F_CENT][FW-2:0]}, bin_i);
    cent20 = from_bin(fld_t'(20), bin_i);

    leap   = (y == '0) ? (c[1:0] == 2'b00) : (y[1:0] == 2'b00);
    at_159 = (h == 8'd1) && (m == 8'd59) && (s == 8'd59);
    sunday = (wd == 8'd1);
    spring = dst_i && (mo == 8'd4)  && sunday && (d <= 8'd7)  && at_159;
    fall   = dst_i && (mo == 8'd10) && sunday && (d >= 8'd25) && at_159 && !fall_done_i;

    c_min = (s == 8'd59);
    c_hr  = c_min && (m == 8'd59);
    c_day = c_hr && (h == 8'd23);
    c_mon = c_day && (d >= month_len(mo, leap));
    c_yr  = c_mon && (mo >= 8'd12);

    nxt_t       = cur_i;
    fall_done_o = fall_done_i;
    hour_chg    = 1'b0;
    h_n         = h;

    nxt_t[F_SEC] = from_bin(c_min ? '0 : s + 8'd1, bin_i);
    if (c_min) nxt_t[F_MIN] = from_bin((m == 8'd59) ? '0 : m + 8'd1, bin_i);
    if (c_hr) begin
      hour_chg = 1'b1;
      h_n      = (h == 8'd23) ? '0 : h + 8'd1;
    end
    if (spring) h_n = fld_t'(3);
    if (fall) begin
      h_n         = fld_t'(1);
      fall_done_o = 1'b1;
    end
    if (c_day) begin
      fall_done_o   = 1'b0;
      nxt_t[F_WDAY] = from_bin((wd >= 8'd7) ? fld_t'(1) : wd + 8'd1, bin_i);
      nxt_t[F_MDAY] = from_bin(c_mon ? fld_t'(1) : d + 8'd1, bin_i);
    end
    if (c_mon) nxt_t[F_MON] = from_bin((mo >= 8'd12) ? fld_t'(1) : mo + 8'd1, bin_i);
    if (c_yr) begin
      nxt_t[F_YEAR] = from_bin((y >= 8'd99) ? '0 : y + 8'd1, bin_i);
      if (y >= 8'd99) nxt_t[F_CENT] = {cur_i[F_CENT][FW-1], cent20[FW-2:0]};
    end
  end

  always_comb begin
    nxt_o         = nxt_t;
    nxt_o[F_HOUR] = hour_chg ? h_raw : cur_i[F_HOUR];
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            bin_mode_i,
  input  logic            h24_mode_i,
  input  logic            dst_en_i,
  input  logic            hold_i,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  logic [FW-1:0]   wr_data_i,
  output logic [FW-1:0]   sec_o,
  output logic [FW-1:0]   min_o,
  output logic [FW-1:0]   hour_o,
  output logic [FW-1:0]   wday_o,
  output logic [FW-1:0]   mday_o,
  output logic [FW-1:0]   month_o,
  output logic [FW-1:0]   year_o,
  output logic [FW-1:0]   cent_o,
  output logic            upd_done_o
);
  logic [NFIELD-1:0][FW-1:0] fld_q, nxt;
  logic pend_q, done_q, fall_q, fall_n, req, go;

  assign req = tick_i | pend_q;
  assign go  = req & ~hold_i & ~wr_en_i;

  rtc_cal_next u_next (
    .cur_i(fld_q), .bin_i(bin_mode_i), .h24_i(h24_mode_i), .dst_i(dst_en_i),
    .fall_done_i(fall_q), .nxt_o(nxt), .fall_done_o(fall_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      fall_q <= 1'b0;
      for (int i = 0; i < NFIELD; i++) fld_q[i] <= rst_val(i);
    end else begin
      pend_q <= req & ~hold_i & wr_en_i;
      done_q <= go;
      if (go) fall_q <= fall_n;
      for (int i = 0; i < NFIELD; i++) begin
        if (wr_en_i && (wr_sel_i == SELW'(i))) fld_q[i] <= wr_data_i;
        else if (go)                           fld_q[i] <= nxt[i];
      end
    end
  end

  assign sec_o      = fld_q[F_SEC];
  assign min_o      = fld_q[F_MIN];
  assign hour_o     = fld_q[F_HOUR];
  assign wday_o     = fld_q[F_WDAY];
  assign mday_o     = fld_q[F_MDAY];
  assign month_o    = fld_q[F_MON];
  assign year_o     = fld_q[F_YEAR];
  assign cent_o     = fld_q[F_CENT];
  assign upd_done_o = done_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            hold_i,
  input logic            wr_en_i,
  input logic [SELW-1:0] wr_sel_i,
  input logic [FW-1:0]   wr_data_i,
  input logic [FW-1:0]   sec_o,
  input logic [FW-1:0]   min_o,
  input logic [FW-1:0]   hour_o,
  input logic [FW-1:0]   wday_o,
  input logic [FW-1:0]   mday_o,
  input logic [FW-1:0]   month_o,
  input logic [FW-1:0]   year_o,
  input logic [FW-1:0]   cent_o,
  input logic            upd_done_o
);
  logic [NFIELD-1:0][FW-1:0] f;
  assign f = {cent_o, year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o};

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (f[$past(wr_sel_i)] == $past(wr_data_i)));

  p_sec_moves_r3: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |-> (sec_o != $past(sec_o)));

  p_cent_msb_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(cent_o[FW-1]));

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !wr_en_i) |=> ($stable(f) && !upd_done_o));

  p_write_defers_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> !upd_done_o);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .hold_i(hold_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o), .year_o(year_o),
  .cent_o(cent_o), .upd_done_o(upd_done_o)
);

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bin = 1'b0, h24 = 1'b1;
  logic dst = 1'b0, hold = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, mn, hr, wd, md, mo, yr, ce;
  logic done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rtc_calendar u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .bin_mode_i(bin), .h24_mode_i(h24),
    .dst_en_i(dst), .hold_i(hold), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sec_o(sec), .min_o(mn), .hour_o(hr), .wday_o(wd),
    .mday_o(md), .month_o(mo), .year_o(yr), .cent_o(ce), .upd_done_o(done)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_all(logic [7:0] h, logic [7:0] m, logic [7:0] s,
                         logic [7:0] w, logic [7:0] dd, logic [7:0] mm,
                         logic [7:0] y, logic [7:0] c);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s); wr(3'd3, w);
    wr(3'd4, dd); wr(3'd5, mm); wr(3'd6, y); wr(3'd7, c);
  endtask

  task automatic do_tick(output logic d);
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1 d = done;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sec", sec, 8'h00); chk("R1 min", mn, 8'h00); chk("R1 hour", hr, 8'h00);
    chk("R1 wday", wd, 8'h01); chk("R1 mday", md, 8'h01); chk("R1 month", mo, 8'h01);
    chk("R1 year", yr, 8'h80); chk("R1 cent", ce, 8'h19); chk("R1 done", {7'd0, done}, 8'h00);
  endtask

  task automatic t_write();
    wr(3'd6, 8'h55); chk("R2 year write", yr, 8'h55);
    wr(3'd3, 8'h04); chk("R2 wday write", wd, 8'h04);
  endtask

  task automatic t_bcd_carry();
    logic d;
    bin = 0; h24 = 1;
    set_all(8'h10, 8'h20, 8'h09, 8'h02, 8'h11, 8'h05, 8'h21, 8'h20);
    do_tick(d);
    chk("R4 bcd nibble carry", sec, 8'h10);
    chk("R3 done pulse", {7'd0, d}, 8'h01);
    @(posedge clk); #1 chk("R3 done one cycle", {7'd0, done}, 8'h00);
    wr(3'd0, 8'h59); do_tick(d);
    chk("R3 sec wrap", sec, 8'h00); chk("R3 min carry", mn, 8'h21);
  endtask

  task automatic t_rollover();
    logic d;
    bin = 0; h24 = 1;
    set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99, 8'h99);
    do_tick(d);
    chk("R3 hour wrap", hr, 8'h00); chk("R3 min wrap", mn, 8'h00);
    chk("R12 wday wrap", wd, 8'h01); chk("R12 month wrap", mo, 8'h01);
    chk("R6 mday wrap", md, 8'h01); chk("R12 year wrap", yr, 8'h00);
    chk("R7 century load keeps msb", ce, 8'hA0);
  endtask

  task automatic t_binary();
    logic d;
    bin = 1; h24 = 1;
    set_all(8'd10, 8'd5, 8'd59, 8'd2, 8'd28, 8'd2, 8'd24, 8'd20);
    do_tick(d);
    chk("R4 binary sec", sec, 8'd0); chk("R4 binary min", mn, 8'd6);
    set_all(8'd23, 8'd59, 8'd59, 8'd2, 8'd28, 8'd2, 8'd24, 8'd20);
    do_tick(d);
    chk("R6 binary leap feb", md, 8'd29); chk("R6 binary leap month", mo, 8'd2);
  endtask

  task automatic t_12h();
    logic d;
    bin = 1; h24 = 0;
    set_all(8'h0B, 8'd59, 8'd59, 8'd2, 8'd10, 8'd6, 8'd30, 8'd20);
    do_tick(d); chk("R5 11am to 12pm binary", hr, 8'h8C);
    wr(3'd1, 8'd59); wr(3'd0, 8'd59);
    do_tick(d); chk("R5 12pm to 1pm binary", hr, 8'h81);
    bin = 0;
    set_all(8'h91, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h30, 8'h20);
    do_tick(d);
    chk("R5 11pm to 12am bcd", hr, 8'h12);
    chk("R5 day advance", md, 8'h16); chk("R12 wday step", wd, 8'h04);
    h24 = 1;
  endtask

  task automatic leap_case(string tag, logic [7:0] dd, logic [7:0] mm,
                           logic [7:0] y, logic [7:0] c,
                           logic [7:0] exp_d, logic [7:0] exp_m);
    logic d;
    set_all(8'h23, 8'h59, 8'h59, 8'h02, dd, mm, y, c);
    do_tick(d);
    chk({tag, " mday"}, md, exp_d); chk({tag, " month"}, mo, exp_m);
  endtask

  task automatic t_leap();
    bin = 0; h24 = 1;
    leap_case("R6 feb28 leap",   8'h28, 8'h02, 8'h24, 8'h20, 8'h29, 8'h02);
    leap_case("R6 feb29 leap",   8'h29, 8'h02, 8'h24, 8'h20, 8'h01, 8'h03);
    leap_case("R6 feb28 common", 8'h28, 8'h02, 8'h23, 8'h20, 8'h01, 8'h03);
    leap_case("R6 y00 c20",      8'h28, 8'h02, 8'h00, 8'h20, 8'h29, 8'h02);
    leap_case("R6 y00 c19",      8'h28, 8'h02, 8'h00, 8'h19, 8'h01, 8'h03);
    leap_case("R6 apr30",        8'h30, 8'h04, 8'h23, 8'h20, 8'h01, 8'h05);
  endtask

  task automatic t_spring();
    logic d;
    bin = 0; h24 = 1; dst = 1;
    set_all(8'h01, 8'h59, 8'h59, 8'h01, 8'h05, 8'h04, 8'h24, 8'h20);
    do_tick(d);
    chk("R8 spring hour", hr, 8'h03); chk("R8 spring min", mn, 8'h00);
    chk("R8 spring sec", sec, 8'h00);
    dst = 0;
    set_all(8'h01, 8'h59, 8'h59, 8'h01, 8'h05, 8'h04, 8'h24, 8'h20);
    do_tick(d); chk("R8 disabled no jump", hr, 8'h02);
    dst = 1;
    set_all(8'h01, 8'h59, 8'h59, 8'h01, 8'h08, 8'h04, 8'h24, 8'h20);
    do_tick(d); chk("R8 second sunday no jump", hr, 8'h02);
  endtask

  task automatic t_fall();
    logic d;
    bin = 0; h24 = 1; dst = 1;
    set_all(8'h01, 8'h59, 8'h59, 8'h01, 8'h27, 8'h10, 8'h24, 8'h20);
    do_tick(d);
    chk("R9 fall back hour", hr, 8'h01); chk("R9 fall back min", mn, 8'h00);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    do_tick(d);
    chk("R9 only once", hr, 8'h02);
    dst = 0;
  endtask

  task automatic t_hold();
    logic d;
    bin = 0; h24 = 1;
    wr(3'd0, 8'h30);
    hold = 1; do_tick(d);
    chk("R10 hold sec", sec, 8'h30); chk("R10 hold no done", {7'd0, d}, 8'h00);
    hold = 0;
  endtask

  task automatic t_collide();
    bin = 0; h24 = 1;
    wr(3'd0, 8'h30);
    @(negedge clk); tick = 1; wr_en = 1; wr_sel = 3'd0; wr_data = 8'h45;
    @(posedge clk); #1;
    chk("R11 write wins", sec, 8'h45); chk("R11 no done yet", {7'd0, done}, 8'h00);
    @(negedge clk); tick = 0; wr_en = 0;
    @(posedge clk); #1;
    chk("R11 deferred update", sec, 8'h46); chk("R11 deferred done", {7'd0, done}, 8'h01);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 t_reset();
    t_write(); t_bcd_carry(); t_rollover(); t_binary(); t_12h();
    t_leap(); t_spring(); t_fall(); t_hold(); t_collide();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule